// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent memory ports, called left and right, and one shared RAM array. Each clock cycle it checks whether both ports are enabled on the same word address. When they are, it picks one owner for that address. The losing port sees an active-low busy flag. While the flag is low, the losing port's write is dropped and its read data register keeps its old value. Data is written and read one byte lane at a time: each port has an upper-lane enable and a lower-lane enable. Reads are synchronous and return data one clock after the request.

A mode input makes the block either a master or a slave, so several blocks can be cascaded to form a wider word. As a master, the block drives its busy outputs from its own arbiter. As a slave, it releases its busy outputs high. It then takes a busy input for each port from an external master, and a low busy input blocks that port's write.

The arbiter is a three-state machine. ARB_IDLE means no contention. ARB_LEFT means the left port owns the contended address. ARB_RIGHT means the right port owns it. The transitions are:
- IDLE_TO_LEFT: a match begins and the left port was already on that address, or both ports arrived in the same cycle.
- IDLE_TO_RIGHT: a match begins and only the right port was already there.
- HOLD: the match continues, so the current owner is kept.
- RELEASE: the match ends, so the machine returns to ARB_IDLE.

The owner is decided in the cycle the match begins, so the loser's access is blocked in that same cycle.

Top module: `dpram_contention_arb`

## Requirements
- R1: In master mode (mode_master=1), both busy outputs are high whenever the two ports are not both enabled on the same address.
- R2: When one port was enabled on an address in the previous cycle and the other port now arrives on that address, the port that arrived first wins. The newcomer's busy output goes low in the cycle it arrives.
- R3: When both ports arrive on the same address in the same cycle, the left port wins and right_busy_n_out goes low.
- R4: The loser's busy output stays low for as long as the match lasts. It returns high in the same cycle that the addresses differ or either enable drops.
- R5: In slave mode (mode_master=0), both busy outputs are high and the internal arbiter blocks nothing. A port whose busy input is low does not write. In master mode the busy inputs have no effect.
- R6: In master mode, the losing port's write is dropped and the winning port's write is carried out.
- R7: While a port is blocked (it loses in master mode, or its busy input is low in slave mode), its read data output keeps its previous value.
- R8: Upper enable = data bits [15:8], lower enable = bits [7:0]. A write changes only the enabled lanes. A read updates only the enabled lanes of read data, and the other lanes keep their values.
- R9: A read that is not blocked presents the array contents on read data after the next rising clock edge.
- R10: If one port writes and the other port reads the same address in the same cycle, the read returns the data from before the write.
- R11: During reset, both busy outputs are high and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = master (arbiter drives busy), 0 = slave (busy inputs used) |
| left_en | input | 1 | Left port enable |
| left_we | input | 1 | Left write (1) / read (0) |
| left_upper | input | 1 | Left upper lane enable |
| left_lower | input | 1 | Left lower lane enable |
| left_addr | input | ADDR_W | Left word address |
| left_wdata | input | 2*LANE_W | Left write data |
| left_rdata | output | 2*LANE_W | Left read data |
| left_busy_n_in | input | 1 | Left busy from an external master (slave mode) |
| left_busy_n_out | output | 1 | Left busy flag, active low |
| right_en | input | 1 | Right port enable |
| right_we | input | 1 | Right write (1) / read (0) |
| right_upper | input | 1 | Right upper lane enable |
| right_lower | input | 1 | Right lower lane enable |
| right_addr | input | ADDR_W | Right word address |
| right_wdata | input | 2*LANE_W | Right write data |
| right_rdata | output | 2*LANE_W | Right read data |
| right_busy_n_in | input | 1 | Right busy from an external master (slave mode) |
| right_busy_n_out | output | 1 | Right busy flag, active low |

## Verification
The assertions assume that port inputs change only between clock edges and that enables are low while reset is applied. The persistence properties also rely on "the previous cycle" meaning a cycle since reset, so the stimulus keeps both ports idle until reset is released.

In slave mode the checks assume that the external master never lets both ports write the same address in one cycle. The stimulus therefore only pairs a write with a read, or uses different addresses, whenever both busy inputs are high. All input changes are made on the falling clock edge.

// File: rtl/dparb_pkg.sv
package dparb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_LEFT  = 2'd1,
        ARB_RIGHT = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dparb_fsm.sv
module dparb_fsm
    import dparb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose
);
    arb_state_t        state_q, state_d;
    logic              prev_l_en, prev_r_en;
    logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
    logic              match, l_was_here, r_was_here;

    assign match      = l_en && r_en && (l_addr == r_addr);
    assign l_was_here = prev_l_en && (prev_l_addr == l_addr);
    assign r_was_here = prev_r_en && (prev_r_addr == r_addr);

    // State register and arrival history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ARB_IDLE;
            prev_l_en   <= 1'b0;
            prev_r_en   <= 1'b0;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
        end else begin
            state_q     <= state_d;
            prev_l_en   <= l_en;
            prev_r_en   <= r_en;
            prev_l_addr <= l_addr;
            prev_r_addr <= r_addr;
        end
    end

    // Next state and loser outputs
    always_comb begin
        state_d = ARB_IDLE;
        l_lose  = 1'b0;
        r_lose  = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (match) begin
                    if (!l_was_here && r_was_here) state_d = ARB_RIGHT;
                    else                           state_d = ARB_LEFT;
                end
            end
            ARB_LEFT:  if (match) state_d = ARB_LEFT;
            ARB_RIGHT: if (match) state_d = ARB_RIGHT;
            default:   state_d = ARB_IDLE;
        endcase
        if (match) begin
            l_lose = (state_d == ARB_RIGHT);
            r_lose = (state_d == ARB_LEFT);
        end
    end
endmodule

// File: rtl/dparb_port_gate.sv
module dparb_port_gate #(
    parameter int LANES = 2
) (
    input  logic             mode_master,
    input  logic             arb_lose,
    input  logic             busy_n_in,
    input  logic             en,
    input  logic             we,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] wr_lanes,
    output logic [LANES-1:0] rd_lanes,
    output logic             busy_n_out
);
    logic blocked;

    always_comb begin
        blocked    = mode_master ? arb_lose : ~busy_n_in;
        busy_n_out = mode_master ? ~arb_lose : 1'b1;
        wr_lanes   = {LANES{en && we && !blocked}} & lane_en;
        rd_lanes   = {LANES{en && !we && !blocked}} & lane_en;
    end
endmodule

// File: rtl/dparb_ram.sv
module dparb_ram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [LANES*LANE_W-1:0] l_wdata,
    input  logic [LANES-1:0]        l_wr,
    input  logic [LANES-1:0]        l_rd,
    output logic [LANES*LANE_W-1:0] l_rdata,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [LANES*LANE_W-1:0] r_wdata,
    input  logic [LANES-1:0]        r_wr,
    input  logic [LANES-1:0]        r_rd,
    output logic [LANES*LANE_W-1:0] r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (l_wr[g]) mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
            if (r_wr[g]) mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                l_rdata[g*LANE_W +: LANE_W] <= '0;
                r_rdata[g*LANE_W +: LANE_W] <= '0;
            end else begin
                if (l_rd[g]) l_rdata[g*LANE_W +: LANE_W] <= mem[l_addr];
                if (r_rd[g]) r_rdata[g*LANE_W +: LANE_W] <= mem[r_addr];
            end
        end
    end
endmodule

// File: rtl/dpram_contention_arb.sv
module dpram_contention_arb #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_master,
    input  logic                  left_en,
    input  logic                  left_we,
    input  logic                  left_upper,
    input  logic                  left_lower,
    input  logic [ADDR_W-1:0]     left_addr,
    input  logic [2*LANE_W-1:0]   left_wdata,
    output logic [2*LANE_W-1:0]   left_rdata,
    input  logic                  left_busy_n_in,
    output logic                  left_busy_n_out,
    input  logic                  right_en,
    input  logic                  right_we,
    input  logic                  right_upper,
    input  logic                  right_lower,
    input  logic [ADDR_W-1:0]     right_addr,
    input  logic [2*LANE_W-1:0]   right_wdata,
    output logic [2*LANE_W-1:0]   right_rdata,
    input  logic                  right_busy_n_in,
    output logic                  right_busy_n_out
);
    localparam int LANES = 2;

    logic             l_lose, r_lose;
    logic [LANES-1:0] l_wr, l_rd, r_wr, r_rd;

    dparb_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (left_en),
        .l_addr (left_addr),
        .r_en   (right_en),
        .r_addr (right_addr),
        .l_lose (l_lose),
        .r_lose (r_lose)
    );

    dparb_port_gate #(.LANES(LANES)) gate_l_i (
        .mode_master (mode_master),
        .arb_lose    (l_lose),
        .busy_n_in   (left_busy_n_in),
        .en          (left_en),
        .we          (left_we),
        .lane_en     ({left_upper, left_lower}),
        .wr_lanes    (l_wr),
        .rd_lanes    (l_rd),
        .busy_n_out  (left_busy_n_out)
    );

    dparb_port_gate #(.LANES(LANES)) gate_r_i (
        .mode_master (mode_master),
        .arb_lose    (r_lose),
        .busy_n_in   (right_busy_n_in),
        .en          (right_en),
        .we          (right_we),
        .lane_en     ({right_upper, right_lower}),
        .wr_lanes    (r_wr),
        .rd_lanes    (r_rd),
        .busy_n_out  (right_busy_n_out)
    );

    dparb_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_addr  (left_addr),
        .l_wdata (left_wdata),
        .l_wr    (l_wr),
        .l_rd    (l_rd),
        .l_rdata (left_rdata),
        .r_addr  (right_addr),
        .r_wdata (right_wdata),
        .r_wr    (r_wr),
        .r_rd    (r_rd),
        .r_rdata (right_rdata)
    );
endmodule

// File: rtl/dparb_checker.sv
module dparb_checker #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_master,
    input logic                left_en,
    input logic [ADDR_W-1:0]   left_addr,
    input logic [2*LANE_W-1:0] left_rdata,
    input logic                left_busy_n_in,
    input logic                left_busy_n_out,
    input logic                right_en,
    input logic [ADDR_W-1:0]   right_addr,
    input logic [2*LANE_W-1:0] right_rdata,
    input logic                right_busy_n_in,
    input logic                right_busy_n_out
);
    logic same;
    assign same = left_en && right_en && (left_addr == right_addr);

    a_r1_no_busy_without_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !same) |-> (left_busy_n_out && right_busy_n_out));

    a_r3_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n_out && !right_busy_n_out));

    a_r1_match_has_loser: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && same) |-> (!left_busy_n_out || !right_busy_n_out));

    a_r4_right_loss_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && same && $past(mode_master && same && !right_busy_n_out))
        |-> !right_busy_n_out);

    a_r4_left_loss_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && same && $past(mode_master && same && !left_busy_n_out))
        |-> !left_busy_n_out);

    a_r5_slave_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> (left_busy_n_out && right_busy_n_out));

    a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master ? !left_busy_n_out : !left_busy_n_in) |=> $stable(left_rdata));

    a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master ? !right_busy_n_out : !right_busy_n_in) |=> $stable(right_rdata));
endmodule

bind dpram_contention_arb dparb_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_master      (mode_master),
    .left_en          (left_en),
    .left_addr        (left_addr),
    .left_rdata       (left_rdata),
    .left_busy_n_in   (left_busy_n_in),
    .left_busy_n_out  (left_busy_n_out),
    .right_en         (right_en),
    .right_addr       (right_addr),
    .right_rdata      (right_rdata),
    .right_busy_n_in  (right_busy_n_in),
    .right_busy_n_out (right_busy_n_out)
);

// File: tb/dpram_contention_arb_tb.sv
module dpram_contention_arb_tb_top;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_master = 1'b1;
    logic le = 0, lwe = 0, lub = 0, llb = 0, lbin = 1;
    logic re = 0, rwe = 0, rub = 0, rlb = 0, rbin = 1;
    logic [AW-1:0] la = '0, ra = '0;
    logic [15:0] lwd = '0, rwd = '0;
    logic [15:0] lrd, rrd;
    logic lbo, rbo;

    always #4 clk = ~clk;

    dpram_contention_arb #(.ADDR_W(AW), .LANE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .left_en(le), .left_we(lwe), .left_upper(lub), .left_lower(llb),
        .left_addr(la), .left_wdata(lwd), .left_rdata(lrd),
        .left_busy_n_in(lbin), .left_busy_n_out(lbo),
        .right_en(re), .right_we(rwe), .right_upper(rub), .right_lower(rlb),
        .right_addr(ra), .right_wdata(rwd), .right_rdata(rrd),
        .right_busy_n_in(rbin), .right_busy_n_out(rbo)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] mm [int];
    logic [15:0] exp_l = '0, exp_r = '0;
    int owner = 0;                       // 0 none, 1 left, 2 right
    bit p_le = 0, p_re = 0;
    int p_la = 0, p_ra = 0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int cur_owner();
        bit m = le && re && (la == ra);
        if (!m) return 0;
        if (owner != 0) return owner;
        if (!(p_le && p_la == int'(la)) && (p_re && p_ra == int'(ra))) return 2;
        return 1;
    endfunction

    function automatic logic [15:0] rdmem(int a);
        return mm.exists(a) ? mm[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lanes(logic [15:0] old, logic [15:0] nw, logic u, logic l);
        return {u ? nw[15:8] : old[15:8], l ? nw[7:0] : old[7:0]};
    endfunction

    task automatic cyc(string tag);
        int o;
        bit bl, br;
        logic [15:0] ol, orr;
        #1;
        o  = cur_owner();
        bl = mode_master ? (o == 2) : !lbin;
        br = mode_master ? (o == 1) : !rbin;
        chk(tag, "left busy", lbo, (mode_master && o == 2) ? 1'b0 : 1'b1);
        chk(tag, "right busy", rbo, (mode_master && o == 1) ? 1'b0 : 1'b1);
        @(posedge clk);
        ol  = rdmem(int'(la));
        orr = rdmem(int'(ra));
        if (le && !lwe && !bl) exp_l = lanes(exp_l, ol, lub, llb);
        if (re && !rwe && !br) exp_r = lanes(exp_r, orr, rub, rlb);
        if (le && lwe && !bl) mm[int'(la)] = lanes(rdmem(int'(la)), lwd, lub, llb);
        if (re && rwe && !br) mm[int'(ra)] = lanes(rdmem(int'(ra)), rwd, rub, rlb);
        owner = o;
        p_le = le; p_la = int'(la);
        p_re = re; p_ra = int'(ra);
        @(negedge clk);
        chk(tag, "left rdata", lrd, exp_l);
        chk(tag, "right rdata", rrd, exp_r);
    endtask

    task automatic setl(logic e, logic w, logic u, logic l, int a, logic [15:0] d);
        le = e; lwe = w; lub = u; llb = l; la = AW'(a); lwd = d;
    endtask

    task automatic setr(logic e, logic w, logic u, logic l, int a, logic [15:0] d);
        re = e; rwe = w; rub = u; rlb = l; ra = AW'(a); rwd = d;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "left busy", lbo, 1'b1);
        chk("R11", "right busy", rbo, 1'b1);
        chk("R11", "left rdata", lrd, 16'h0);
        chk("R11", "right rdata", rrd, 16'h0);
        rst_n = 1'b1;

        // R1 / R5: distinct addresses, busy inputs low are ignored in master mode
        lbin = 0; rbin = 0;
        setl(1, 1, 1, 1, 5, 16'hA5A5); setr(1, 1, 1, 1, 9, 16'h1234); cyc("R1");
        lbin = 1; rbin = 1;
        setl(1, 1, 1, 1, 30, 16'h3030); setr(1, 1, 1, 1, 20, 16'h0F0F); cyc("R5");
        // R9: cross reads
        setl(1, 0, 1, 1, 9, 0); setr(1, 0, 1, 1, 5, 0); cyc("R9");
        // R3 / R6: simultaneous arrival on 20, both write
        setl(1, 1, 1, 1, 20, 16'h1111); setr(1, 1, 1, 1, 20, 16'h2222); cyc("R3");
        // R4 / R7: match persists, right read held
        setl(1, 0, 1, 1, 20, 0); setr(1, 0, 1, 1, 20, 0); cyc("R7");
        // R4: release when addresses differ
        setr(1, 0, 1, 1, 21, 0); cyc("R4");
        setl(0, 0, 0, 0, 0, 0); setr(1, 0, 1, 1, 20, 0); cyc("R6");
        // R2: right arrives first on 30, left arrives later with a write
        setr(1, 0, 1, 1, 30, 0); cyc("R2");
        setl(1, 1, 1, 1, 30, 16'h7777); cyc("R2");
        setl(1, 0, 1, 1, 30, 0); cyc("R4");
        setl(0, 0, 0, 0, 0, 0); cyc("R4");
        setl(1, 0, 1, 1, 30, 0); setr(0, 0, 0, 0, 0, 0); cyc("R6");
        // R8: lane masking
        setl(1, 1, 1, 1, 40, 16'h1234); cyc("R8");
        setl(1, 1, 1, 0, 40, 16'hABCD); cyc("R8");
        setl(1, 0, 0, 1, 40, 0); cyc("R8");
        setl(1, 0, 1, 1, 40, 0); cyc("R8");
        // R5: slave mode
        setl(0, 0, 0, 0, 0, 0);
        mode_master = 0;
        lbin = 0;
        setl(1, 1, 1, 1, 50, 16'hDEAD); setr(1, 1, 1, 1, 51, 16'hBEEF); cyc("R5");
        setl(1, 0, 1, 1, 51, 0); setr(1, 0, 1, 1, 50, 0); cyc("R7");
        lbin = 1;
        setl(1, 0, 1, 1, 51, 0); setr(1, 0, 1, 1, 50, 0); cyc("R5");
        // R10: same-cycle write/read on one address
        setl(1, 1, 1, 1, 51, 16'h5A5A); setr(1, 0, 1, 1, 51, 0); cyc("R10");
        setl(0, 0, 0, 0, 0, 0); setr(1, 0, 1, 1, 51, 0); cyc("R10");
        setr(0, 0, 0, 0, 0, 0);
        mode_master = 1;
        cyc("R1");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule